// File: doc/BRIEF.md
# DQS Read Gating Window Controller

This block produces the read-strobe gate enable for each byte lane of a DDR3 read path. The core clock runs at four times the DRAM clock, so one core tick is a quarter of a DRAM cycle. When a read is issued, each lane waits for its own programmed number of ticks and then opens its gate. The gate must open inside the strobe preamble (about 0.9 cycle) and close inside the postamble (about 0.3 cycle).

Two closing modes are available. In the fixed mode the gate stays open for exactly one BL8 burst of 16 ticks. In the strobe-tracking mode the gate closes on the fourth falling edge of the lane's strobe, so the programmed delay needs less accuracy. If that fourth edge never arrives, a timeout closes the gate.

A built-in training sweep tries delays 0 to 15 on every lane, always in the fixed mode. A trial passes when the lane sees exactly four strobe falling edges inside the window. When a lane has one contiguous run of passing delays, the sweep returns the centre of that run. Otherwise it flags the lane as having no pass, or as having more than one run.

Top module: `dqsg_ctrl`

## Requirements
- R1: During and after reset, all gate enables, `trn_rd_req`, `trn_busy`, `trn_done`, `lane_ok`, `err_none`, `err_multi` and `trn_dly` are 0.
- R2: Lane n takes its delay d from bits 8n+7 down to 8n of `gate_dly`. When `rd_issue` is sampled high at clock edge E, `gate_en[n]` goes high at edge E+d+1.
- R3: With `active_mode` low when the read was issued, a gate that opens at edge O closes at edge O+16, so it is high for exactly 16 ticks.
- R4: With `active_mode` high when the read was issued, the gate closes at the edge where it samples the fourth falling edge of `dqs_in` since opening. A falling edge is `dqs_in` sampled 1 and then 0 on consecutive edges.
- R5: In strobe-tracking mode, a gate that has not yet seen four falling edges closes at edge O+32.
- R6: A lane ignores `rd_issue` while it is waiting or open.
- R7: A pulse on `trn_start` runs 16 trials with delays 0,1,...,15, in that order. Each trial gives one `trn_rd_req` pulse, applies the same trial delay to every lane, and uses 16-tick windows whatever the level of `active_mode`. During the sweep, `rd_issue` and `trn_start` are ignored.
- R8: A trial passes on a lane when exactly four falling edges are sampled while that lane's gate is open.
- R9: A lane whose passing trials form exactly one contiguous run from a to b gets `lane_ok` set and byte (a+b)/2 (rounded down) in `trn_dly`.
- R10: A lane with no passing trial gets `err_none` set and byte 0.
- R11: A lane with two or more separate passing runs gets `err_multi` set and byte 0.
- R12: On the edge that accepts `trn_start`, the block clears `lane_ok`, `err_none`, `err_multi` and `trn_done` and sets `trn_busy`. At the end of the sweep, `trn_busy` falls and `trn_done` rises, both on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-cycle tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_issue | input | 1 | Read command issued, one-tick pulse |
| dqs_in | input | LANES | Sampled strobe level per lane |
| gate_dly | input | LANES*8 | Packed per-lane gate delay in ticks |
| active_mode | input | 1 | 1 = strobe-tracking close, 0 = fixed 16-tick window |
| trn_start | input | 1 | Start a training sweep |
| gate_en | output | LANES | Per-lane gate enable |
| trn_rd_req | output | 1 | Read request for the current training trial |
| trn_dly | output | LANES*8 | Trained per-lane delays |
| trn_busy | output | 1 | Sweep in progress |
| trn_done | output | 1 | Sweep finished, results valid |
| lane_ok | output | LANES | Lane found a single passing run |
| err_none | output | LANES | Lane found no passing delay |
| err_multi | output | LANES | Lane found more than one passing run |

## Verification
The assertions assume three things about the inputs:
- `rd_issue` pulses arrive only when the lanes can accept them.
- The strobe toggles no faster than once per tick.
- `trn_start` is a single pulse.

The window-width properties depend on the mode that was latched when each read was issued. For that reason the bench changes `active_mode` only while every gate is closed.

In the bench, strobe bursts are launched on the tick after a gate is seen to rise. This keeps each passing trial's four falling edges inside the window. Trials that must fail simply leave the strobe quiet. With the passing trials fixed per lane this way, the bench predicts every training result in advance.

// File: rtl/dqsg_pkg.sv
`timescale 1ns/1ps
package dqsg_pkg;

  typedef enum logic [1:0] {LN_IDLE, LN_ARM, LN_OPEN} lane_st_e;
  typedef enum logic [1:0] {TR_IDLE, TR_ISSUE, TR_WAIT, TR_EVAL} trn_st_e;

  // falling edge between two consecutive samples
  function automatic logic is_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // centre of a run, rounded down
  function automatic logic [15:0] mid_point(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[16:1];
  endfunction

  // run counter that sticks at 2 (meaning "two or more")
  function automatic logic [1:0] run_inc(input logic [1:0] n);
    return (n == 2'd2) ? n : n + 2'd1;
  endfunction

endpackage

// File: rtl/dqsg_lane.sv
`timescale 1ns/1ps
module dqsg_lane
  import dqsg_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned BURST = 16,
  parameter int unsigned FALLS = 4,
  parameter int unsigned TMO   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dly,
  input  logic          act_mode,
  input  logic          dqs,
  output logic          gate,
  output logic          close_p,
  output logic          pass_p,
  output logic          act_q
);
  localparam int unsigned OW = $clog2(TMO);
  localparam int unsigned FW = $clog2(FALLS + 2);

  lane_st_e      st;
  logic [DW-1:0] wcnt;
  logic [OW-1:0] ocnt;
  logic [FW-1:0] fcnt;
  logic [FW-1:0] fnext;
  logic          dqs_q;
  logic          fall;
  logic          close_c;

  assign fall  = is_fall(dqs_q, dqs);
  assign fnext = (fcnt == FW'(FALLS + 1)) ? fcnt : fcnt + FW'(fall);

  always_comb begin
    if (act_q)
      close_c = (fall && (fcnt == FW'(FALLS - 1))) || (ocnt == OW'(TMO - 1));
    else
      close_c = (ocnt == OW'(BURST - 1));
  end

  assign gate    = (st == LN_OPEN);
  assign close_p = gate && close_c;
  assign pass_p  = close_p && (fnext == FW'(FALLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= LN_IDLE;
      wcnt  <= '0;
      ocnt  <= '0;
      fcnt  <= '0;
      dqs_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      dqs_q <= dqs;
      case (st)
        LN_IDLE: if (start) begin
          st    <= LN_ARM;
          wcnt  <= '0;
          act_q <= act_mode;
        end
        LN_ARM: begin
          if (wcnt == dly) begin
            st   <= LN_OPEN;
            ocnt <= '0;
            fcnt <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        LN_OPEN: begin
          if (close_c) begin
            st <= LN_IDLE;
          end else begin
            ocnt <= ocnt + 1'b1;
            fcnt <= fnext;
          end
        end
        default: st <= LN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dqsg_region.sv
`timescale 1ns/1ps
module dqsg_region
  import dqsg_pkg::*;
#(
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic          pass,
  input  logic [SW-1:0] idx,
  output logic [SW-1:0] first,
  output logic [SW-1:0] last,
  output logic [1:0]    nruns
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      prev  <= 1'b0;
      first <= '0;
      last  <= '0;
      nruns <= '0;
    end else if (upd) begin
      prev <= pass;
      if (pass) begin
        last <= idx;
        if (!prev) begin
          nruns <= run_inc(nruns);
          if (nruns == 2'd0) first <= idx;
        end
      end
    end
  end
endmodule

// File: rtl/dqsg_train.sv
`timescale 1ns/1ps
module dqsg_train
  import dqsg_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned STEPS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LANES-1:0]    close_p,
  input  logic [LANES-1:0]    pass_p,
  output logic                rd_req,
  output logic [DW-1:0]       step,
  output logic                busy,
  output logic                done,
  output logic [LANES*DW-1:0] dly_out,
  output logic [LANES-1:0]    ok,
  output logic [LANES-1:0]    enone,
  output logic [LANES-1:0]    emulti
);
  localparam int unsigned SW = $clog2(STEPS);

  trn_st_e             st;
  logic [SW-1:0]       k;
  logic [LANES-1:0]    seen;
  logic [LANES-1:0]    seen_n;
  logic                clr;
  logic [LANES-1:0]    ok_n, none_n, multi_n;
  logic [LANES*DW-1:0] dly_n;

  assign clr    = (st == TR_IDLE) && start;
  assign rd_req = (st == TR_ISSUE);
  assign step   = DW'(k);
  assign seen_n = seen | close_p;

  for (genvar l = 0; l < LANES; l++) begin : g_trk
    logic [SW-1:0] first, last;
    logic [1:0]    nruns;
    logic [15:0]   mid;

    dqsg_region #(.SW(SW)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .upd  ((st == TR_WAIT) && close_p[l] && !seen[l]),
      .pass (pass_p[l]),
      .idx  (k),
      .first(first),
      .last (last),
      .nruns(nruns)
    );

    assign mid        = mid_point(16'(first), 16'(last));
    assign ok_n[l]    = (nruns == 2'd1);
    assign none_n[l]  = (nruns == 2'd0);
    assign multi_n[l] = (nruns == 2'd2);
    assign dly_n[l*DW +: DW] = ok_n[l] ? DW'(mid) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= TR_IDLE;
      k       <= '0;
      seen    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      ok      <= '0;
      enone   <= '0;
      emulti  <= '0;
      dly_out <= '0;
    end else begin
      case (st)
        TR_IDLE: if (start) begin
          st     <= TR_ISSUE;
          k      <= '0;
          busy   <= 1'b1;
          done   <= 1'b0;
          ok     <= '0;
          enone  <= '0;
          emulti <= '0;
        end
        TR_ISSUE: begin
          st   <= TR_WAIT;
          seen <= '0;
        end
        TR_WAIT: begin
          seen <= seen_n;
          if (&seen_n) begin
            if (k == SW'(STEPS - 1)) begin
              st <= TR_EVAL;
            end else begin
              k  <= k + 1'b1;
              st <= TR_ISSUE;
            end
          end
        end
        TR_EVAL: begin
          ok      <= ok_n;
          enone   <= none_n;
          emulti  <= multi_n;
          dly_out <= dly_n;
          busy    <= 1'b0;
          done    <= 1'b1;
          st      <= TR_IDLE;
        end
        default: st <= TR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dqsg_ctrl.sv
`timescale 1ns/1ps
module dqsg_ctrl #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned BURST = 16,
  parameter int unsigned FALLS = 4,
  parameter int unsigned STEPS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_issue,
  input  logic [LANES-1:0]    dqs_in,
  input  logic [LANES*DW-1:0] gate_dly,
  input  logic                active_mode,
  input  logic                trn_start,
  output logic [LANES-1:0]    gate_en,
  output logic                trn_rd_req,
  output logic [LANES*DW-1:0] trn_dly,
  output logic                trn_busy,
  output logic                trn_done,
  output logic [LANES-1:0]    lane_ok,
  output logic [LANES-1:0]    err_none,
  output logic [LANES-1:0]    err_multi
);
  localparam int unsigned TMO = 2 * BURST;

  logic             lane_start;
  logic             eff_act;
  logic [DW-1:0]    step_dly;
  logic [LANES-1:0] close_p;
  logic [LANES-1:0] pass_p;
  logic [LANES-1:0] lane_act;

  // the sweep owns the lanes: external reads are ignored and windows are fixed
  assign lane_start = trn_busy ? trn_rd_req : rd_issue;
  assign eff_act    = active_mode & ~trn_busy;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] dsel;
    assign dsel = trn_busy ? step_dly : gate_dly[l*DW +: DW];

    dqsg_lane #(.DW(DW), .BURST(BURST), .FALLS(FALLS), .TMO(TMO)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (lane_start),
      .dly     (dsel),
      .act_mode(eff_act),
      .dqs     (dqs_in[l]),
      .gate    (gate_en[l]),
      .close_p (close_p[l]),
      .pass_p  (pass_p[l]),
      .act_q   (lane_act[l])
    );
  end

  dqsg_train #(.LANES(LANES), .DW(DW), .STEPS(STEPS)) u_train (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (trn_start),
    .close_p(close_p),
    .pass_p (pass_p),
    .rd_req (trn_rd_req),
    .step   (step_dly),
    .busy   (trn_busy),
    .done   (trn_done),
    .dly_out(trn_dly),
    .ok     (lane_ok),
    .enone  (err_none),
    .emulti (err_multi)
  );
endmodule

// File: rtl/dqsg_ctrl_chk.sv
`timescale 1ns/1ps
module dqsg_ctrl_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned BURST = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] gate_en,
  input logic [LANES-1:0] lane_act,
  input logic             trn_rd_req,
  input logic             trn_busy,
  input logic             trn_done,
  input logic [LANES-1:0] lane_ok,
  input logic [LANES-1:0] err_none,
  input logic [LANES-1:0] err_multi
);
  localparam int unsigned CW = $clog2(2 * BURST + 2);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    logic [CW-1:0] wcnt;

    always_ff @(posedge clk) begin
      if (!rst_n) wcnt <= '0;
      else if (gate_en[l]) wcnt <= wcnt + 1'b1;
      else wcnt <= '0;
    end

    assert_passive_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en[l] && $past(gate_en[l]) && !$past(lane_act[l])) |-> (wcnt == CW'(BURST)));

    assert_max_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt <= CW'(2 * BURST));

    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lane_ok[l], err_none[l], err_multi[l]}));
  end

  assert_stale_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trn_busy |-> (lane_ok == '0 && err_none == '0 && err_multi == '0 && !trn_done));

  assert_req_in_sweep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trn_rd_req |-> trn_busy);

  assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trn_done) |-> $past(trn_busy));
endmodule

bind dqsg_ctrl dqsg_ctrl_chk #(.LANES(LANES), .BURST(BURST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_en   (gate_en),
  .lane_act  (lane_act),
  .trn_rd_req(trn_rd_req),
  .trn_busy  (trn_busy),
  .trn_done  (trn_done),
  .lane_ok   (lane_ok),
  .err_none  (err_none),
  .err_multi (err_multi)
);

// File: tb/dqsg_ctrl_test.sv
`timescale 1ns/1ps
module dqsg_ctrl_test;
  localparam int LANES = 4;
  localparam int DW    = 8;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                rd_issue;
  logic [LANES-1:0]    dqs_in;
  logic [LANES*DW-1:0] gate_dly;
  logic                active_mode;
  logic                trn_start;
  logic [LANES-1:0]    gate_en;
  logic                trn_rd_req;
  logic [LANES*DW-1:0] trn_dly;
  logic                trn_busy;
  logic                trn_done;
  logic [LANES-1:0]    lane_ok;
  logic [LANES-1:0]    err_none;
  logic [LANES-1:0]    err_multi;

  dqsg_ctrl uut (.*);

  always #2.5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    nchk++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model, advanced on every rising edge ----------------
  bit  m_en = 0;
  int  m_cyc = 0;
  int  m_st[LANES];
  int  m_open_at[LANES];
  int  m_opened[LANES];
  int  m_falls[LANES];
  bit  m_prev[LANES];
  bit  m_act[LANES];

  always @(posedge clk) begin
    m_cyc++;
    for (int l = 0; l < LANES; l++) begin
      if (!rst_n) begin
        m_st[l] = 0; m_prev[l] = 0;
      end else begin
        bit d, f;
        d = dqs_in[l];
        f = m_prev[l] && !d;
        m_prev[l] = d;
        case (m_st[l])
          0: if (rd_issue) begin
               m_open_at[l] = m_cyc + int'(gate_dly[l*DW +: DW]) + 1;
               m_act[l] = active_mode;
               m_st[l] = 1;
             end
          1: if (m_cyc == m_open_at[l]) begin
               m_st[l] = 2; m_opened[l] = m_cyc; m_falls[l] = 0;
             end
          default: begin
            if (f) m_falls[l]++;
            if (!m_act[l] && m_cyc == m_opened[l] + 16) m_st[l] = 0;
            else if (m_act[l] && (m_falls[l] == 4 || m_cyc == m_opened[l] + 32)) m_st[l] = 0;
          end
        endcase
      end
    end
  end

  // ---------------- strobe driver, comparison and window monitors ----------------
  logic [LANES-1:0] auto_b = '0;
  logic [15:0] tmask[LANES];
  int  pos[LANES];
  bit  gprev[LANES];
  int  wid[LANES];
  int  rises[LANES];
  int  nreq = 0;

  initial begin
    for (int l = 0; l < LANES; l++) begin
      pos[l] = -1; gprev[l] = 0; wid[l] = 0; rises[l] = 0; tmask[l] = '0;
    end
    dqs_in = '0;
  end

  always @(negedge clk) begin
    if (trn_rd_req) nreq++;
    for (int l = 0; l < LANES; l++) begin
      if (m_en)
        chk(gate_en[l] == (m_st[l] == 2), m_act[l] ? "R2/R4/R5/R6 gate" : "R2/R3/R6 gate",
            gate_en[l], m_st[l] == 2);
      if (gate_en[l]) wid[l]++;
      if (!gate_en[l] && gprev[l]) begin
        if (trn_busy) chk(wid[l] == 16, "R7 sweep window width", wid[l], 16);
        wid[l] = 0;
      end
      if (gate_en[l] && !gprev[l]) begin
        bit want;
        rises[l]++;
        want = trn_busy ? tmask[l][nreq - 1] : auto_b[l];
        if (want) pos[l] = 0;
      end
      if (pos[l] >= 16) begin
        dqs_in[l] = 1'b0; pos[l] = -1;
      end else if (pos[l] >= 0) begin
        dqs_in[l] = ((pos[l] % 4) < 2);
        pos[l]++;
      end
      gprev[l] = gate_en[l];
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_issue = 1'b1; @(negedge clk); rd_issue = 1'b0;
  endtask

  task automatic run_sweep(output bit ok);
    int t = 0;
    nreq = 0;
    trn_start = 1'b1; @(negedge clk); trn_start = 1'b0;
    chk(trn_busy == 1'b1, "R12 busy after start", trn_busy, 1);
    chk(trn_done == 1'b0 && err_none == '0 && err_multi == '0 && lane_ok == '0,
        "R12 stale flags cleared", {trn_done, err_none, err_multi, lane_ok}, 0);
    rd_issue = 1'b1; @(negedge clk); rd_issue = 1'b0;   // R7: ignored during the sweep
    trn_start = 1'b1; @(negedge clk); trn_start = 1'b0; // R7: ignored during the sweep
    while (!trn_done && t < 3000) begin @(negedge clk); t++; end
    ok = trn_done;
    chk(trn_done == 1'b1, "R12 sweep finished", trn_done, 1);
    chk(trn_busy == 1'b0, "R12 busy cleared", trn_busy, 0);
    chk(nreq == 16, "R7 one request per trial delay", nreq, 16);
  endtask

  initial begin
    bit ok;
    rst_n = 1'b0; rd_issue = 1'b0; active_mode = 1'b0; trn_start = 1'b0;
    gate_dly = '0;
    ticks(3);
    chk(gate_en == '0 && trn_rd_req == 1'b0 && trn_busy == 1'b0 && trn_done == 1'b0,
        "R1 reset outputs", {gate_en, trn_rd_req, trn_busy, trn_done}, 0);
    chk(lane_ok == '0 && err_none == '0 && err_multi == '0 && trn_dly == '0,
        "R1 reset results", trn_dly, 0);
    rst_n = 1'b1;
    m_en = 1'b1;
    ticks(2);

    // fixed window, distinct delays per lane, extra issue while busy (R6)
    gate_dly = {8'd12, 8'd5, 8'd1, 8'd0};
    for (int l = 0; l < LANES; l++) rises[l] = 0;
    pulse_rd(); ticks(2); pulse_rd();
    ticks(60);
    chk(rises[3] == 1 && rises[0] == 1, "R6 issue while busy ignored", rises[3], 1);

    // fixed window with strobe bursts: width must not change (R3)
    auto_b = 4'b1111;
    gate_dly = {8'd2, 8'd9, 8'd4, 8'd7};
    pulse_rd(); ticks(50);

    // strobe-tracking close, lane 2 without strobe times out (R4, R5)
    active_mode = 1'b1;
    auto_b = 4'b1011;
    gate_dly = {8'd3, 8'd7, 8'd2, 8'd9};
    pulse_rd(); ticks(60);
    pulse_rd(); ticks(60);

    // largest delay value with timeout close (R2, R5)
    auto_b = 4'b0000;
    gate_dly = {8'd255, 8'd0, 8'd128, 8'd17};
    pulse_rd(); ticks(300);

    // first sweep: single run, none, two runs, single trial at the top (R7..R11)
    m_en = 1'b0;
    tmask[0] = 16'h01E0; tmask[1] = 16'h0000; tmask[2] = 16'h1E0C; tmask[3] = 16'h8000;
    run_sweep(ok);
    chk(lane_ok == 4'b1001, "R8 R9 lane_ok", lane_ok, 4'b1001);
    chk(err_none == 4'b0010, "R10 no pass", err_none, 4'b0010);
    chk(err_multi == 4'b0100, "R11 two runs", err_multi, 4'b0100);
    chk(trn_dly == 32'h0F000006, "R9 R10 R11 trained delays", trn_dly, 32'h0F000006);

    // second sweep: stale errors must clear, all lanes succeed (R12, R9)
    tmask[0] = 16'h0001; tmask[1] = 16'hFFFF; tmask[2] = 16'h0FF0; tmask[3] = 16'h0006;
    run_sweep(ok);
    chk(lane_ok == 4'b1111 && err_none == '0 && err_multi == '0, "R9 R12 all lanes ok",
        {lane_ok, err_none, err_multi}, 12'hF00);
    chk(trn_dly == 32'h01070700, "R9 centres", trn_dly, 32'h01070700);

    // normal gating uses the programmed word again after a sweep (R2)
    active_mode = 1'b0;
    ticks(4);
    m_en = 1'b1;
    gate_dly = {8'd6, 8'd0, 8'd3, 8'd1};
    pulse_rd(); ticks(40);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule